// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs the two-wire management link to an Ethernet PHY. It generates the management clock from the system clock through a divider, and it performs one register read or one register write per request. A request carries a direction flag, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The data line reaches a tristate pad through a separate output value and an output enable.

A frame starts with a run of ones. The header follows, then a two-bit turnaround and sixteen data bits. For a read, the block releases the line during the turnaround and shifts in the PHY's answer. After the data bits it runs one extra clock period with the line released. A one-cycle done pulse ends the frame. On a read, the captured value is valid on the read-data port when done is high.

Top module: `mdio_frame_master`

## Requirements
- R1: A synchronous active-high reset forces the management clock low, the output enable low, busy low and done low.
- R2: Every frame begins with 32 bit periods in which the line is driven (enable high) with value 1.
- R3: The next 14 bit periods carry the header MSB first. The header is start code 01, then the opcode (10 for read, 01 for write), then the 5-bit PHY address, then the 5-bit register address.
- R4: For a write, the block drives the turnaround as 1 then 0, followed by the 16 write-data bits MSB first.
- R5: For a read, the enable is low for both turnaround bits and all 16 data bits. The line is sampled in the last system clock of each high half of the management clock, MSB first. The assembled word appears on the read-data port with done.
- R6: Bit period 65 of a frame (the one after the data bits) runs with the enable low. Between frames the enable and the management clock stay low.
- R7: Each bit period lasts 2*HALF_DIV system clocks: HALF_DIV clocks low, then HALF_DIV clocks high. The line value and the enable change only at the start of a bit period, when the clock goes low.
- R8: A start pulse is accepted only while busy is low. A start raised during a frame leaves that frame unchanged.
- R9: Done is high for exactly one system clock, 130*HALF_DIV clocks after the accepting edge. Busy is low from that same edge, so a new start may be accepted while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken when busy is low |
| isRead | input | 1 | 1 for a register read, 0 for a write |
| phyAddr | input | 5 | Target PHY address |
| regAddr | input | 5 | Target register address |
| wrData | input | 16 | Value to write |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rdData | output | 16 | Word read from the PHY, valid with done |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Data value toward the pad |
| mdioOe | output | 1 | Pad output enable |
| mdioIn | input | 1 | Data value sampled from the pad |

## Verification
The bench builds the block with HALF_DIV set to 3. That is an odd divider, so the low-half and high-half counts both wrap mid-way through the count range. It also keeps a frame at 390 clocks, which leaves room for several reads and writes with distinct address and data patterns: all ones, all zeros and alternating bits. A start pulse during a frame and a start on the same cycle as done are both within reach of the run.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int IDX_W      = 7;
  localparam int PRE_BITS   = 32;
  localparam int HDR_END    = 46;
  localparam int DATA_START = 48;
  localparam int DATA_END   = 64;
  localparam int LAST_BIT   = 64;

  typedef struct packed {
    logic             load;
    logic             advance;
    logic             sample;
    logic [IDX_W-1:0] bitIdx;
    logic [IDX_W-1:0] nextIdx;
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic         mdc,
  output mdio_strobe_t strobe
);
  localparam int CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

  logic [CW-1:0]    halfCnt;
  logic             phaseHigh;
  logic             busyQ;
  logic             doneQ;
  logic [IDX_W-1:0] idx;
  logic             halfEnd;
  logic             lastBit;

  assign halfEnd = busyQ && (halfCnt == CW'(HALF_DIV - 1));
  assign lastBit = (idx == IDX_W'(LAST_BIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt   <= '0;
      phaseHigh <= 1'b0;
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      idx       <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start) begin
          busyQ     <= 1'b1;
          halfCnt   <= '0;
          phaseHigh <= 1'b0;
          idx       <= '0;
        end
      end else if (halfEnd) begin
        halfCnt <= '0;
        if (!phaseHigh) begin
          phaseHigh <= 1'b1;
        end else begin
          phaseHigh <= 1'b0;
          if (lastBit) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load    = !busyQ && start;
    strobe.advance = halfEnd && phaseHigh && !lastBit;
    strobe.sample  = halfEnd && phaseHigh;
    strobe.bitIdx  = idx;
    strobe.nextIdx = idx + 1'b1;
  end

  assign busy = busyQ;
  assign done = doneQ;
  assign mdc  = phaseHigh;
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  mdio_strobe_t strobe,
  input  logic         isRead,
  input  logic [4:0]   phyAddr,
  input  logic [4:0]   regAddr,
  input  logic [15:0]  wrData,
  input  logic         mdioIn,
  output logic         mdioOut,
  output logic         mdioOe,
  output logic [15:0]  rdData
);
  logic        readQ;
  logic [31:0] txQ;
  logic [15:0] rxQ;
  logic [15:0] hdrWord;
  logic [1:0]  opcode;

  assign opcode  = isRead ? 2'b10 : 2'b01;
  assign hdrWord = (16'(1) << 14) | (16'(opcode) << 12)
                 | (16'(phyAddr) << 7) | (16'(regAddr) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      readQ   <= 1'b0;
      txQ     <= '0;
      rxQ     <= '0;
      mdioOut <= 1'b0;
      mdioOe  <= 1'b0;
    end else begin
      if (strobe.load) begin
        readQ   <= isRead;
        txQ     <= {hdrWord[15:2], 2'b10, wrData};
        mdioOut <= 1'b1;
        mdioOe  <= 1'b1;
      end else if (strobe.advance) begin
        if (strobe.nextIdx < IDX_W'(PRE_BITS)) begin
          mdioOut <= 1'b1;
          mdioOe  <= 1'b1;
        end else if (strobe.nextIdx < IDX_W'(HDR_END) ||
                     (!readQ && strobe.nextIdx < IDX_W'(DATA_END))) begin
          mdioOut <= txQ[31];
          mdioOe  <= 1'b1;
          txQ     <= {txQ[30:0], 1'b0};
        end else begin
          mdioOut <= 1'b0;
          mdioOe  <= 1'b0;
        end
      end
      if (strobe.sample && readQ &&
          strobe.bitIdx >= IDX_W'(DATA_START) && strobe.bitIdx < IDX_W'(DATA_END)) begin
        rxQ <= {rxQ[14:0], mdioIn};
      end
    end
  end

  assign rdData = rxQ;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        isRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regAddr,
  input  logic [15:0] wrData,
  output logic        busy,
  output logic        done,
  output logic [15:0] rdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdio_strobe_t strobe;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .done(done), .mdc(mdc), .strobe(strobe)
  );

  mdio_dpath u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .isRead(isRead), .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdData(rdData)
  );
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mdc && !mdioOe));

  assert_idle_release_R6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdioOe && !mdc));

  assert_change_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdioOut) || !$stable(mdioOe)) |-> !mdc);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> busy || done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy || $past(start)));
endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;
  localparam int PERIOD = 10;
  localparam int HALF   = 3;
  localparam int FRAME_CLKS = 130 * HALF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic isRead = 1'b0;
  logic [4:0] phyAddr = '0;
  logic [4:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic busy, done, mdc, mdioOut, mdioOe, mdioIn;
  logic [15:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  int k = -1;
  bit doneE = 0;
  bit mRead = 0;
  logic [15:0] mHdr = '0;
  logic [15:0] mWr = '0;
  logic [15:0] phyWord = '0;

  always #(PERIOD/2) clk = ~clk;

  mdio_frame_master #(.HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .start(start), .isRead(isRead),
    .phyAddr(phyAddr), .regAddr(regAddr), .wrData(wrData),
    .busy(busy), .done(done), .rdData(rdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // PHY side: answers during the read data bits, pulled up otherwise
  always_comb begin
    int b;
    b = (k >= 0) ? k / (2 * HALF) : -1;
    if (mRead && b >= 48 && b < 64) mdioIn = phyWord[63 - b];
    else mdioIn = 1'b1;
  end

  // Reference model state, advanced on the active edge
  always @(posedge clk) begin
    if (rst) begin
      k <= -1; doneE <= 0;
    end else begin
      doneE <= 0;
      if (k < 0) begin
        if (start) begin
          k <= 0;
          mRead <= isRead;
          mHdr <= {2'b01, (isRead ? 2'b10 : 2'b01), phyAddr, regAddr, 2'b00};
          mWr <= wrData;
        end
      end else if (k == FRAME_CLKS - 1) begin
        k <= -1; doneE <= 1;
      end else begin
        k <= k + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string bitTag(input int b);
    if (b < 32) return "R2";
    if (b < 46) return "R3";
    if (b == 64) return "R6";
    return mRead ? "R5" : "R4";
  endfunction

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      if (k < 0) begin
        check(mdc == 1'b0, "R6 mdc idle", mdc, 0);
        check(mdioOe == 1'b0, "R6 oe idle", mdioOe, 0);
        check(busy == 1'b0, "R9 busy idle", busy, 0);
      end else begin
        int b, ph;
        bit eOe, eOut;
        b = k / (2 * HALF);
        ph = k % (2 * HALF);
        check(busy == 1'b1, "R8 busy in frame", busy, 1);
        check(mdc == (ph >= HALF), "R7 mdc", mdc, (ph >= HALF));
        eOut = 1'b0;
        if (b < 32) begin eOe = 1; eOut = 1; end
        else if (b < 46) begin eOe = 1; eOut = mHdr[15 - (b - 32)]; end
        else if (b == 64) eOe = 0;
        else if (mRead) eOe = 0;
        else if (b == 46) begin eOe = 1; eOut = 1; end
        else if (b == 47) begin eOe = 1; eOut = 0; end
        else begin eOe = 1; eOut = mWr[15 - (b - 48)]; end
        check(mdioOe == eOe, {bitTag(b), " oe"}, mdioOe, eOe);
        if (eOe) check(mdioOut == eOut, {bitTag(b), " data"}, mdioOut, eOut);
      end
      check(done == doneE, "R9 done", done, doneE);
      if (doneE && mRead) check(rdData == phyWord, "R5 read data", rdData, phyWord);
    end
  end

  task automatic request(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic [15:0] pw);
    @(negedge clk);
    isRead = rd; phyAddr = pa; regAddr = ra; wrData = wd; phyWord = pw;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mdc == 0, "R1 mdc", mdc, 0);
    check(mdioOe == 0, "R1 oe", mdioOe, 0);
    check(busy == 0, "R1 busy", busy, 0);
    check(done == 0, "R1 done", done, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    request(0, 5'd1, 5'd0, 16'h8000, 16'h0);      // R4 write, default PHY address
    request(1, 5'd1, 5'd5, 16'h0, 16'hA5C3);      // R5 read
    request(1, 5'd31, 5'd31, 16'h0, 16'hFFFF);    // R3 all-ones fields
    request(0, 5'd0, 5'd0, 16'h5555, 16'h0);      // R3 all-zeros fields

    // R8: a start during the frame with other fields must change nothing
    @(negedge clk);
    isRead = 1; phyAddr = 5'd10; regAddr = 5'd21; phyWord = 16'h0001; start = 1;
    @(negedge clk);
    start = 0;
    repeat (200) @(negedge clk);
    isRead = 0; phyAddr = 5'd3; regAddr = 5'd3; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    check(rdData == 16'h0001, "R8 frame kept read", rdData, 16'h0001);

    // R9: start asserted in the done cycle is accepted
    isRead = 0; phyAddr = 5'd17; regAddr = 5'd9; wrData = 16'hC3A5; start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R9 restart on done", busy, 1);
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule